// File: doc/BRIEF.md
# Load-Store Address Overlap Detector

This block reports which pairs of in-flight memory accesses could touch a common byte, so that an issue scheduler can hold back accesses that are not safe to run in parallel. Each of N slots presents a valid bit, an address and a two-bit size code. The block turns the low nibble of the address and the size into a 16-bit byte-lane strobe. Address bits 15 down to 4 serve as a coarse tag. Two slots are flagged when their tags match and their strobes share at least one lane.

The test is deliberately conservative. Address bits above the tag are never compared, so accesses that alias in those bits are reported as overlapping. That costs throughput and never correctness. Within one 16-byte slot the strobes keep disjoint halves or quarters apart. The per-slot strobes are also driven out, so they can be reused directly as byte write enables. An output register can be enabled by parameter, which adds one cycle of latency.

Top module: `lsov_overlap_top`

## Requirements
- R1: For a valid slot, the size code selects the number of contiguous set strobe bits: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R2: The strobe run starts at lane addr[3:0] rounded down to a multiple of the access size. Only addr[3] is used for 8 bytes, addr[3:2] for 4 bytes, addr[3:1] for 2 bytes and addr[3:0] for 1 byte. A misaligned access therefore lands on the aligned lanes below it.
- R3: An invalid slot drives an all-zero strobe, and every overlap bit in its row and its column is 0.
- R4: Two distinct valid slots are flagged when addr[15:4] is equal for both and their strobes share at least one lane. Overlap bit i*N+j refers to the pair (i, j). Slot i's strobe sits at bits 16*i+15 down to 16*i.
- R5: Two slots whose addr[15:4] differ are never flagged.
- R6: Address bits 16 and above have no effect. Slots that differ only in those bits are still flagged when R4 holds.
- R7: The overlap matrix is symmetric, and its diagonal bits are always 0.
- R8: With the output register enabled, both outputs follow the inputs one clock later and read 0 while reset is asserted. With it disabled, both outputs follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_vld | input | N | Valid flag for each slot |
| ent_addr | input | N*ADDR_W | Address of each slot; slot i at bits ADDR_W*i+ADDR_W-1 down to ADDR_W*i |
| ent_size | input | 2*N | Size code of each slot; slot i at bits 2*i+1 down to 2*i |
| ovl_mat | output | N*N | Pairwise overlap flags; bit i*N+j is pair (i, j) |
| lane_strb | output | 16*N | Byte-lane strobe of each slot |

## Verification
The bench builds two copies of the block with N=4 and 32-bit addresses side by side: one with the output register enabled and one without. Driving both copies from the same stimulus exposes the one-cycle latency and the reset clearing of the registered copy. The other copy shows the same-cycle response. Four slots are enough to give every row and column a partner, so that symmetry, diagonal masking and invalid-slot masking can be seen across all twelve off-diagonal pairs. A pseudo-random sweep confined to two tags and varying upper bits reaches aliasing, intra-slot hits and misses in many combinations.

// File: rtl/lsov_pkg.sv
package lsov_pkg;
  localparam int unsigned SLOT_LG2 = 4;
  localparam int unsigned LANES    = 1 << SLOT_LG2;
  localparam int unsigned SIZE_W   = 2;

  typedef enum logic [SIZE_W-1:0] {
    SZ_B1 = 2'b00,
    SZ_B2 = 2'b01,
    SZ_B4 = 2'b10,
    SZ_B8 = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsov_lane_mask.sv
module lsov_lane_mask
  import lsov_pkg::*;
(
  input  logic                vld,
  input  logic [SIZE_W-1:0]   size,
  input  logic [SLOT_LG2-1:0] addr_lo,
  output logic [LANES-1:0]    mask
);
  logic [LANES-1:0]    base;
  logic [SLOT_LG2-1:0] offs;

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_B1: begin
        base = LANES'(16'h0001);
        offs = addr_lo;
      end
      SZ_B2: begin
        base = LANES'(16'h0003);
        offs = {addr_lo[SLOT_LG2-1:1], 1'b0};
      end
      SZ_B4: begin
        base = LANES'(16'h000F);
        offs = {addr_lo[SLOT_LG2-1:2], 2'b00};
      end
      default: begin
        base = LANES'(16'h00FF);
        offs = {addr_lo[SLOT_LG2-1], 3'b000};
      end
    endcase
  end

  assign mask = vld ? (base << offs) : '0;
endmodule

// File: rtl/lsov_pair_cmp.sv
module lsov_pair_cmp
  import lsov_pkg::*;
#(
  parameter int unsigned TAG_W = 12
) (
  input  logic             vld_a,
  input  logic             vld_b,
  input  logic [TAG_W-1:0] tag_a,
  input  logic [TAG_W-1:0] tag_b,
  input  logic [LANES-1:0] mask_a,
  input  logic [LANES-1:0] mask_b,
  output logic             hit
);
  logic tag_eq;
  logic lane_share;

  assign tag_eq     = (tag_a == tag_b);
  assign lane_share = |(mask_a & mask_b);
  assign hit        = vld_a & vld_b & tag_eq & lane_share;
endmodule

// File: rtl/lsov_out_stage.sv
module lsov_out_stage #(
  parameter int unsigned W   = 8,
  parameter bit          REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (REG) begin : g_reg
      logic         ld_en;
      logic [W-1:0] q_r;
      logic [W-1:0] q_nxt;

      assign ld_en = 1'b1;

      always_comb begin
        q_nxt = q_r;
        if (ld_en) q_nxt = d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end

      assign q = q_r;
    end else begin : g_thru
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/lsov_overlap_top.sv
module lsov_overlap_top
  import lsov_pkg::*;
#(
  parameter int unsigned N       = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned TAG_HI  = 15,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        ent_vld,
  input  logic [N*ADDR_W-1:0] ent_addr,
  input  logic [N*SIZE_W-1:0] ent_size,
  output logic [N*N-1:0]      ovl_mat,
  output logic [N*LANES-1:0]  lane_strb
);
  localparam int unsigned TAG_W = TAG_HI - SLOT_LG2 + 1;
  localparam int unsigned MAT_W = N * N;
  localparam int unsigned STB_W = N * LANES;
  localparam int unsigned OUT_W = MAT_W + STB_W;

  logic [TAG_W-1:0] tag_w  [N];
  logic [LANES-1:0] mask_w [N];
  logic [STB_W-1:0] strb_w;
  logic [MAT_W-1:0] ovl_w;
  logic [OUT_W-1:0] out_q;

  // per-slot tag slice and lane strobe
  for (genvar i = 0; i < N; i++) begin : g_ent
    assign tag_w[i] = ent_addr[i*ADDR_W+SLOT_LG2 +: TAG_W];

    lsov_lane_mask u_mask (
      .vld     (ent_vld[i]),
      .size    (ent_size[i*SIZE_W +: SIZE_W]),
      .addr_lo (ent_addr[i*ADDR_W +: SLOT_LG2]),
      .mask    (mask_w[i])
    );

    assign strb_w[i*LANES +: LANES] = mask_w[i];
  end

  // pairwise compare; diagonal tied low
  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i == j) begin : g_diag
        assign ovl_w[i*N+j] = 1'b0;
      end else begin : g_pair
        lsov_pair_cmp #(.TAG_W(TAG_W)) u_cmp (
          .vld_a  (ent_vld[i]),
          .vld_b  (ent_vld[j]),
          .tag_a  (tag_w[i]),
          .tag_b  (tag_w[j]),
          .mask_a (mask_w[i]),
          .mask_b (mask_w[j]),
          .hit    (ovl_w[i*N+j])
        );
      end
    end
  end

  lsov_out_stage #(.W(OUT_W), .REG(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ovl_w, strb_w}),
    .q     (out_q)
  );

  assign ovl_mat   = out_q[STB_W +: MAT_W];
  assign lane_strb = out_q[0 +: STB_W];
endmodule

// File: rtl/lsov_overlap_chk.sv
module lsov_overlap_chk
  import lsov_pkg::*;
#(
  parameter int unsigned N       = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned TAG_HI  = 15,
  parameter bit          REG_OUT = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N-1:0]        ent_vld,
  input logic [N*ADDR_W-1:0] ent_addr,
  input logic [N*SIZE_W-1:0] ent_size,
  input logic [N*LANES-1:0]  strb_w,
  input logic [N*N-1:0]      ovl_w,
  input logic [N*N-1:0]      ovl_mat
);
  localparam int unsigned TAG_W = TAG_HI - SLOT_LG2 + 1;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_ck_ent
    assert_strb_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ent_vld[i] |-> ($countones(strb_w[i*LANES +: LANES]) == (1 << ent_size[i*SIZE_W +: SIZE_W])))
      else $error("lane count mismatch slot %0d", i);

    assert_invalid_strb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ent_vld[i] |-> (strb_w[i*LANES +: LANES] == '0))
      else $error("invalid slot %0d has strobe", i);

    assert_no_self_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ovl_w[i*N+i])
      else $error("diagonal set for slot %0d", i);

    for (genvar j = 0; j < N; j++) begin : g_ck_pair
      assert_sym_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_w[i*N+j] == ovl_w[j*N+i])
        else $error("asymmetric pair %0d,%0d", i, j);

      assert_inv_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ent_vld[i] || !ent_vld[j]) |-> !ovl_w[i*N+j])
        else $error("invalid pair %0d,%0d flagged", i, j);

      assert_tag_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_addr[i*ADDR_W+SLOT_LG2 +: TAG_W] != ent_addr[j*ADDR_W+SLOT_LG2 +: TAG_W])
          |-> !ovl_w[i*N+j])
        else $error("tag mismatch flagged %0d,%0d", i, j);

      if (i != j) begin : g_ck_hit
        assert_alias_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
          (ent_vld[i] && ent_vld[j] &&
           (ent_addr[i*ADDR_W+SLOT_LG2 +: TAG_W] == ent_addr[j*ADDR_W+SLOT_LG2 +: TAG_W]) &&
           (ent_addr[i*ADDR_W +: ADDR_W] != ent_addr[j*ADDR_W +: ADDR_W]) &&
           ((strb_w[i*LANES +: LANES] & strb_w[j*LANES +: LANES]) != '0))
            |-> ovl_w[i*N+j])
          else $error("missed hit %0d,%0d", i, j);
      end
    end
  end

  if (REG_OUT) begin : g_ck_reg
    assert_reg_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (ovl_mat == $past(ovl_w)))
      else $error("registered matrix not one cycle behind");
  end else begin : g_ck_comb
    assert_comb_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (ovl_mat == ovl_w))
      else $error("combinational matrix differs");
  end
endmodule

bind lsov_overlap_top lsov_overlap_chk #(
  .N(N), .ADDR_W(ADDR_W), .TAG_HI(TAG_HI), .REG_OUT(REG_OUT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ent_vld  (ent_vld),
  .ent_addr (ent_addr),
  .ent_size (ent_size),
  .strb_w   (strb_w),
  .ovl_w    (ovl_w),
  .ovl_mat  (ovl_mat)
);

// File: tb/tb_lsov_overlap_top.sv
module tb_lsov_overlap_top;
  localparam int CLK_NS = 10;
  localparam int N      = 4;
  localparam int AW     = 32;
  localparam int L      = 16;

  logic clk;
  logic rst_n;
  logic [N-1:0]    ent_vld;
  logic [N*AW-1:0] ent_addr;
  logic [N*2-1:0]  ent_size;
  logic [N*N-1:0]  ovl_r,  ovl_c;
  logic [N*L-1:0]  strb_r, strb_c;

  logic        vl [N];
  logic [31:0] ad [N];
  logic [1:0]  sz [N];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  lsov_overlap_top #(.N(N), .ADDR_W(AW), .TAG_HI(15), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ent_vld(ent_vld), .ent_addr(ent_addr),
    .ent_size(ent_size), .ovl_mat(ovl_r), .lane_strb(strb_r));

  lsov_overlap_top #(.N(N), .ADDR_W(AW), .TAG_HI(15), .REG_OUT(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .ent_vld(ent_vld), .ent_addr(ent_addr),
    .ent_size(ent_size), .ovl_mat(ovl_c), .lane_strb(strb_c));

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // byte span from requirements R1/R2: size bytes starting at low nibble rounded down
  function automatic logic [15:0] exp_mask(input logic v, input logic [1:0] s, input logic [31:0] a);
    int bytes, start;
    logic [31:0] run;
    if (!v) return 16'h0;
    bytes = 1 << s;
    start = int'(a[3:0]) - (int'(a[3:0]) % bytes);
    run   = (32'h1 << bytes) - 32'h1;
    return 16'(run << start);
  endfunction

  function automatic logic [N*L-1:0] exp_strb();
    logic [N*L-1:0] r;
    for (int i = 0; i < N; i++) r[i*L +: L] = exp_mask(vl[i], sz[i], ad[i]);
    return r;
  endfunction

  function automatic logic [N*N-1:0] exp_ovl();
    logic [N*N-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (i != j && vl[i] && vl[j] && ad[i][15:4] == ad[j][15:4] &&
            (exp_mask(vl[i], sz[i], ad[i]) & exp_mask(vl[j], sz[j], ad[j])) != 16'h0)
          r[i*N+j] = 1'b1;
    return r;
  endfunction

  task automatic pack();
    for (int i = 0; i < N; i++) begin
      ent_vld[i]          = vl[i];
      ent_addr[i*AW +: AW] = ad[i];
      ent_size[i*2 +: 2]  = sz[i];
    end
  endtask

  task automatic clear_slots();
    for (int i = 0; i < N; i++) begin
      vl[i] = 1'b0; ad[i] = 32'h0; sz[i] = 2'b00;
    end
  endtask

  // drive at negedge, check unregistered copy 1ns later, registered copy next negedge
  task automatic apply(input string req);
    logic [N*N-1:0] eo;
    logic [N*L-1:0] es;
    @(negedge clk);
    pack();
    eo = exp_ovl();
    es = exp_strb();
    #1;
    check(ovl_c == eo,  req, "comb matrix",  64'(ovl_c),  64'(eo));
    check(strb_c == es, req, "comb strobe",  strb_c,      es);
    @(negedge clk);
    check(ovl_r == eo,  req, "reg matrix",   64'(ovl_r),  64'(eo));
    check(strb_r == es, req, "reg strobe",   strb_r,      es);
  endtask

  task automatic t_reset();
    clear_slots();
    vl[0] = 1; ad[0] = 32'h100; sz[0] = 2'b11;
    vl[1] = 1; ad[1] = 32'h104; sz[1] = 2'b00;
    pack();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ovl_r == '0,  "R8", "matrix in reset", 64'(ovl_r), 64'h0);
    check(strb_r == '0, "R8", "strobe in reset", strb_r,     64'h0);
    check(ovl_c[1] == 1'b1, "R8", "comb in reset", 64'(ovl_c[1]), 64'h1);
    rst_n = 1'b1;
  endtask

  task automatic t_sizes();
    clear_slots();
    vl[0] = 1; ad[0] = 32'h2000_0007; sz[0] = 2'b00;
    vl[1] = 1; ad[1] = 32'h2000_0007; sz[1] = 2'b01;
    vl[2] = 1; ad[2] = 32'h2000_0007; sz[2] = 2'b10;
    vl[3] = 1; ad[3] = 32'h2000_0007; sz[3] = 2'b11;
    apply("R1");
    check(strb_c[0*L +: L] == 16'h0080, "R2", "byte at 7",    strb_c[0*L +: L], 16'h0080);
    check(strb_c[1*L +: L] == 16'h00C0, "R2", "half at 7",    strb_c[1*L +: L], 16'h00C0);
    check(strb_c[2*L +: L] == 16'h00F0, "R2", "word at 7",    strb_c[2*L +: L], 16'h00F0);
    check(strb_c[3*L +: L] == 16'h00FF, "R1", "dword at 7",   strb_c[3*L +: L], 16'h00FF);
    sz[0] = 2'b11; ad[0] = 32'h2000_000D;
    sz[1] = 2'b10; ad[1] = 32'h2000_000E;
    sz[2] = 2'b01; ad[2] = 32'h2000_000F;
    sz[3] = 2'b00; ad[3] = 32'h2000_000F;
    apply("R2");
    check(strb_c[0*L +: L] == 16'hFF00, "R2", "dword upper half", strb_c[0*L +: L], 16'hFF00);
    check(strb_c[3*L +: L] == 16'h8000, "R2", "top byte",         strb_c[3*L +: L], 16'h8000);
  endtask

  task automatic t_half_split();
    clear_slots();
    vl[0] = 1; ad[0] = 32'h0000_1230; sz[0] = 2'b00;
    vl[1] = 1; ad[1] = 32'h0000_1238; sz[1] = 2'b11;
    apply("R4");
    check(ovl_c[0*N+1] == 1'b0, "R4", "byte vs other half", 64'(ovl_c[1]), 64'h0);
    ad[0] = 32'h0000_1239;
    apply("R4");
    check(ovl_c[0*N+1] == 1'b1, "R4", "byte inside dword",  64'(ovl_c[1]), 64'h1);
    check(ovl_c[1*N+0] == 1'b1, "R7", "mirror of pair",      64'(ovl_c[N]), 64'h1);
    check(ovl_c[0] == 1'b0 && ovl_c[N+1] == 1'b0, "R7", "diagonal", 64'(ovl_c), 64'h12);
  endtask

  task automatic t_tag();
    clear_slots();
    vl[0] = 1; ad[0] = 32'h0000_4440; sz[0] = 2'b10;
    vl[1] = 1; ad[1] = 32'h0000_4450; sz[1] = 2'b10;
    vl[2] = 1; ad[2] = 32'h0000_C440; sz[2] = 2'b10;
    apply("R5");
    check(ovl_c == '0, "R5", "distinct tags", 64'(ovl_c), 64'h0);
    ad[1] = 32'hABCD_4442; sz[1] = 2'b00;
    apply("R6");
    check(ovl_c[0*N+1] == 1'b1, "R6", "alias above bit 15", 64'(ovl_c[1]), 64'h1);
  endtask

  task automatic t_invalid();
    clear_slots();
    for (int i = 0; i < N; i++) begin
      vl[i] = 1; ad[i] = 32'h0000_0800; sz[i] = 2'b11;
    end
    vl[2] = 1'b0;
    apply("R3");
    check(strb_c[2*L +: L] == '0, "R3", "invalid strobe", strb_c[2*L +: L], 64'h0);
    check(ovl_c[2*N +: N] == '0 && ovl_c[2] == 1'b0 && ovl_c[N+2] == 1'b0 && ovl_c[3*N+2] == 1'b0,
          "R3", "invalid row/col", 64'(ovl_c), 64'(exp_ovl()));
  endtask

  task automatic t_latency();
    logic [N*N-1:0] old_o;
    clear_slots();
    vl[0] = 1; ad[0] = 32'h10; sz[0] = 2'b01;
    vl[1] = 1; ad[1] = 32'h11; sz[1] = 2'b00;
    apply("R8");
    old_o = exp_ovl();
    ad[1] = 32'h14;
    @(negedge clk);
    pack();
    #1;
    check(ovl_r == old_o,    "R8", "reg holds old", 64'(ovl_r), 64'(old_o));
    check(ovl_c == exp_ovl(), "R8", "comb is new",  64'(ovl_c), 64'(exp_ovl()));
    @(negedge clk);
    check(ovl_r == exp_ovl(), "R8", "reg updated",  64'(ovl_r), 64'(exp_ovl()));
  endtask

  task automatic t_sweep();
    logic [31:0] st;
    st = 32'h1234_5678;
    for (int k = 0; k < 60; k++) begin
      for (int i = 0; i < N; i++) begin
        st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
        vl[i] = (st[31:29] != 3'b000);
        sz[i] = st[1:0];
        ad[i] = {st[27:16] & 12'h003, 4'h0, 11'h0A5, st[2], st[7:4]};
      end
      apply("R4");
    end
  endtask

  initial begin
    rst_n = 1'b0;
    ent_vld = '0; ent_addr = '0; ent_size = '0;
    t_reset();
    t_sizes();
    t_half_split();
    t_tag();
    t_invalid();
    t_latency();
    t_sweep();
    done = 1;
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
      wait (done);
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule